// File: doc/BRIEF.md
# Misaligned Load/Store Access Sequencer

This block sits between the execute stage of a three-stage 32-bit pipeline and a word-wide data RAM that has one cycle of read latency. For every load or store it forms the effective address in its own adder, from a base operand plus a sign-extended 12-bit offset. It then drives the RAM word address, the byte-lane write enables and the lane-aligned write data.

An access whose bytes all fall inside one 32-bit word uses one RAM cycle. An access that spills into the following word is split into two RAM cycles. The first cycle goes to the lower word. The second goes to the next word, built from a registered copy of the first word address. During that second cycle the block raises `stall` so that the pipeline holds. For loads, the two returned words are joined and shifted down to the access offset. The result is then cut to the access width and extended, and it appears on `ld_data` with `ld_valid`.

The RAM is little-endian: byte 0 of a word is bits 7:0.

Top module: `mls_seq`

## Requirements
- R1: In the cycle a request is accepted (`req_valid` high while `stall` is low), `ram_en` is 1 and `ram_addr` equals bits 31:2 of `base + sign_extend(imm)`. When there is neither a request nor a stall, `ram_en` is 0.
- R2: The size code on `req_size` is 00 for a byte, 01 for a halfword, and 10 or 11 for a word. An access is split when its byte offset (address bits 1:0) plus its size in bytes exceeds 4. A split access raises `stall` in the cycle after acceptance, so a byte access never stalls.
- R3: `stall` is high for exactly one cycle per split access. In that cycle `ram_en` is 1 and `ram_addr` is the first word address plus one, wrapping at the top of the address space. Any request presented during that cycle is ignored and causes no RAM write.
- R4: After an aligned access is accepted, `stall` stays low. A new request may be accepted in the very next cycle.
- R5: A load returns `ld_valid` for one cycle. This is the cycle after acceptance for an aligned load, and the second cycle after acceptance for a split load. `ld_data` then holds the addressed bytes in little-endian order, with the lowest address in bits 7:0. Stores never raise `ld_valid`.
- R6: A byte or halfword load with `req_unsigned` = 0 is sign-extended from its top bit. With `req_unsigned` = 1 it is zero-extended.
- R7: A store enables write lane k (bit k of `ram_we`, data bits 8k+7:8k) for each addressed byte. The lane holds the store-data byte whose index is the byte's distance from the effective address. Lanes in the first word are written in the acceptance cycle, and lanes in the next word in the stall cycle. Disabled lanes carry unspecified data. A load drives `ram_we` = 0.
- R8: Reset (`rst_n` low) clears `stall` and `ld_valid` at once and abandons any split access in progress. Afterwards no second-word access and no load result appear for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Memory access request from execute |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 1x word |
| req_unsigned | input | 1 | Zero-extend narrow loads |
| base | input | 32 | Base register operand |
| imm | input | 12 | Address offset, sign-extended |
| st_data | input | 32 | Store data, byte 0 in bits 7:0 |
| stall | output | 1 | Pipeline hold during second word access |
| ram_en | output | 1 | RAM access this cycle |
| ram_addr | output | 30 | RAM word address |
| ram_we | output | 4 | Byte-lane write enables |
| ram_wdata | output | 32 | Lane-aligned write data |
| ram_rdata | input | 32 | RAM read data, one cycle after the address |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Aligned and extended load result |

## Verification
Word, halfword and byte loads are issued at every byte offset. These patterns separate accesses that stay inside one word from those that must be split: a halfword at offset 1 must not stall, while one at offset 3 must. Signed and unsigned narrow loads use data whose top bit is set, which exposes any mix-up between sign and zero extension. Split stores are read back through loads to prove that both lanes of both words landed. Further cases cover a word access that wraps past the top address, a foreign store request presented during a stall, and a reset taken in the middle of a split load.

// File: rtl/mls_seq.sv
module mls_seq #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_store,
  input  logic [1:0]           req_size,
  input  logic                 req_unsigned,
  input  logic [XLEN-1:0]      base,
  input  logic [IMM_W-1:0]     imm,
  input  logic [XLEN-1:0]      st_data,
  output logic                 stall,
  output logic                 ram_en,
  output logic [XLEN-$clog2(XLEN/8)-1:0] ram_addr,
  output logic [XLEN/8-1:0]    ram_we,
  output logic [XLEN-1:0]      ram_wdata,
  input  logic [XLEN-1:0]      ram_rdata,
  output logic                 ld_valid,
  output logic [XLEN-1:0]      ld_data
);
  localparam int NB    = XLEN / 8;
  localparam int OFF_W = $clog2(NB);
  localparam int WA_W  = XLEN - OFF_W;

  logic [XLEN-1:0]   eff;
  logic [OFF_W-1:0]  off;
  logic [OFF_W:0]    nbytes;
  logic [NB-1:0]     mask0;
  logic [2*NB-1:0]   wide_be;
  logic [2*XLEN-1:0] wide_wd;
  logic              split, issue;

  assign eff    = base + {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  assign off    = eff[OFF_W-1:0];
  assign nbytes = (req_size == 2'd0) ? (OFF_W+1)'(1) :
                  (req_size == 2'd1) ? (OFF_W+1)'(2) : (OFF_W+1)'(NB);
  assign mask0  = (req_size == 2'd0) ? NB'(1) :
                  (req_size == 2'd1) ? NB'(3) : {NB{1'b1}};
  assign split  = (({1'b0, off} + nbytes) > (OFF_W+1)'(NB));
  assign issue  = req_valid & ~stall;

  assign wide_be = {{NB{1'b0}}, mask0} << off;
  assign wide_wd = {{XLEN{1'b0}}, st_data} << {off, 3'b000};

  logic [WA_W-1:0]  wa_q;
  logic [NB-1:0]    hi_be_q;
  logic [XLEN-1:0]  hi_wd_q, lo_q;
  logic [OFF_W-1:0] off_q;
  logic [1:0]       size_q;
  logic             st_q, uns_q, split_q, fin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall   <= 1'b0;
      fin     <= 1'b0;
      wa_q    <= '0;
      hi_be_q <= '0;
      hi_wd_q <= '0;
      lo_q    <= '0;
      off_q   <= '0;
      size_q  <= '0;
      st_q    <= 1'b0;
      uns_q   <= 1'b0;
      split_q <= 1'b0;
    end else begin
      stall <= issue & split;
      fin   <= (issue & ~req_store & ~split) | (stall & ~st_q);
      if (issue) begin
        wa_q    <= eff[XLEN-1:OFF_W];
        hi_be_q <= wide_be[2*NB-1:NB];
        hi_wd_q <= wide_wd[2*XLEN-1:XLEN];
        off_q   <= off;
        size_q  <= req_size;
        st_q    <= req_store;
        uns_q   <= req_unsigned;
        split_q <= split;
      end
      if (stall) lo_q <= ram_rdata;
    end
  end

  assign ram_en    = stall | req_valid;
  assign ram_addr  = stall ? wa_q + 1'b1 : eff[XLEN-1:OFF_W];
  assign ram_we    = stall ? (st_q ? hi_be_q : '0)
                           : ((req_valid & req_store) ? wide_be[NB-1:0] : '0);
  assign ram_wdata = stall ? hi_wd_q : wide_wd[XLEN-1:0];

  logic [2*XLEN-1:0] pair;
  logic [XLEN-1:0]   sh;
  assign pair = split_q ? {ram_rdata, lo_q} : {{XLEN{1'b0}}, ram_rdata};
  assign sh   = XLEN'(pair >> {off_q, 3'b000});

  always_comb begin
    case (size_q)
      2'd0:    ld_data = {{(XLEN-8){~uns_q & sh[7]}}, sh[7:0]};
      2'd1:    ld_data = {{(XLEN-16){~uns_q & sh[15]}}, sh[15:0]};
      default: ld_data = sh;
    endcase
  end

  assign ld_valid = fin;
endmodule

module mls_seq_chk #(
  parameter int WA_W = 30,
  parameter int NB   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [1:0]      req_size,
  input logic [1:0]      base_lo,
  input logic [1:0]      imm_lo,
  input logic            stall,
  input logic            ram_en,
  input logic [WA_W-1:0] ram_addr,
  input logic [NB-1:0]   ram_we,
  input logic            ld_valid
);
  logic [1:0] c_off;
  logic [2:0] c_len;
  logic       c_cross;
  assign c_off   = base_lo + imm_lo;
  assign c_len   = (req_size == 2'd0) ? 3'd1 : (req_size == 2'd1) ? 3'd2 : 3'd4;
  assign c_cross = ({1'b0, c_off} + c_len) > 3'd4;

  AST_STALL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall); // R3
  AST_SPLIT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !stall && c_cross) |=> stall); // R2
  AST_ALIGNED_NOSTALL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !stall && !c_cross) |=> !stall); // R4
  AST_NEXT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (ram_en && ram_addr == $past(ram_addr) + 1'b1)); // R3
  AST_HI_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && ram_we != '0) |-> ram_we[0]); // R7
  AST_SPLIT_LOAD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && ram_we == '0) |=> ld_valid); // R5
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (!stall && !ld_valid)); // R8
endmodule

bind mls_seq mls_seq_chk #(.WA_W(WA_W), .NB(NB)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_size(req_size),
  .base_lo(base[1:0]), .imm_lo(imm[1:0]), .stall(stall), .ram_en(ram_en),
  .ram_addr(ram_addr), .ram_we(ram_we), .ld_valid(ld_valid)
);

// File: tb/sim_mls_seq.sv
module sim_mls_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0, req_unsigned = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] base = '0, st_data = '0;
  logic [11:0] imm = '0;
  logic        stall, ram_en, ld_valid;
  logic [29:0] ram_addr;
  logic [3:0]  ram_we;
  logic [31:0] ram_wdata, ld_data;
  logic [31:0] ram_rdata = '0;

  always #10 clk = ~clk;

  mls_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_unsigned(req_unsigned), .base(base), .imm(imm),
    .st_data(st_data), .stall(stall), .ram_en(ram_en), .ram_addr(ram_addr),
    .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .ld_valid(ld_valid), .ld_data(ld_data)
  );

  logic [31:0] mem [64];
  logic [7:0]  shd [256];

  always @(posedge clk) begin
    if (ram_en) begin
      for (int j = 0; j < 4; j++)
        if (ram_we[j]) mem[ram_addr[5:0]][j*8 +: 8] <= ram_wdata[j*8 +: 8];
      ram_rdata <= mem[ram_addr[5:0]];
    end
  end

  int nchk = 0, nerr = 0;
  bit m_stall = 0, pend = 0, sec_store = 0;
  int pcnt = 0;
  logic [29:0] sec_addr;
  logic [3:0]  sec_we;
  logic [31:0] sec_wd, pexp;
  string       ptag = "R5", stag = "R4";

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] lanes(input logic [3:0] m);
    logic [31:0] r;
    for (int j = 0; j < 4; j++) r[j*8 +: 8] = {8{m[j]}};
    return r;
  endfunction

  task automatic cycle(input bit v, input bit st, input logic [1:0] sz, input bit un,
                       input logic [31:0] b, input logic [11:0] im, input logic [31:0] d);
    logic [31:0] eff, a, wd_lo, wd_hi, val;
    logic [3:0]  we_lo, we_hi;
    bit sp;
    int n;
    @(negedge clk);
    rst_n = 1'b1;
    req_valid = v; req_store = st; req_size = sz; req_unsigned = un;
    base = b; imm = im; st_data = d;
    #2;
    eff = b + {{20{im[11]}}, im};
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    we_lo = 0; we_hi = 0; wd_lo = 0; wd_hi = 0; sp = 0; val = 0;
    for (int i = 0; i < n; i++) begin
      a = eff + i;
      val[i*8 +: 8] = shd[a[7:0]];
      if (a[31:2] == eff[31:2]) begin
        we_lo[a[1:0]] = 1'b1; wd_lo[a[1:0]*8 +: 8] = d[i*8 +: 8];
      end else begin
        sp = 1; we_hi[a[1:0]] = 1'b1; wd_hi[a[1:0]*8 +: 8] = d[i*8 +: 8];
      end
    end
    if (n == 1) val = un ? {24'd0, val[7:0]} : {{24{val[7]}}, val[7:0]};
    if (n == 2) val = un ? {16'd0, val[15:0]} : {{16{val[15]}}, val[15:0]};

    chk(stall == m_stall, stag, {31'd0, stall}, {31'd0, m_stall});
    if (m_stall) begin
      chk(ram_en == 1'b1, "R3", {31'd0, ram_en}, 32'd1);
      chk(ram_addr == sec_addr, "R3", {2'b0, ram_addr}, {2'b0, sec_addr});
      chk(ram_we == (sec_store ? sec_we : 4'd0), "R7", {28'd0, ram_we}, {28'd0, sec_we});
      if (sec_store)
        chk(((ram_wdata ^ sec_wd) & lanes(sec_we)) == 0, "R7", ram_wdata, sec_wd);
    end else if (v) begin
      chk(ram_en == 1'b1, "R1", {31'd0, ram_en}, 32'd1);
      chk(ram_addr == eff[31:2], "R1", {2'b0, ram_addr}, {2'b0, eff[31:2]});
      chk(ram_we == (st ? we_lo : 4'd0), "R7", {28'd0, ram_we}, {28'd0, we_lo});
      if (st) chk(((ram_wdata ^ wd_lo) & lanes(we_lo)) == 0, "R7", ram_wdata, wd_lo);
    end else begin
      chk(ram_en == 1'b0, "R1", {31'd0, ram_en}, 32'd0);
    end
    chk(ld_valid == (pend && pcnt == 0), "R5", {31'd0, ld_valid}, {31'd0, pend && pcnt == 0});
    if (pend && pcnt == 0) chk(ld_data == pexp, ptag, ld_data, pexp);

    if (pend) begin
      if (pcnt == 0) pend = 0; else pcnt--;
    end
    if (m_stall) begin
      m_stall = 0; stag = "R3";
    end else if (v) begin
      if (st) begin
        for (int i = 0; i < n; i++) begin a = eff + i; shd[a[7:0]] = d[i*8 +: 8]; end
      end else begin
        pend = 1; pcnt = sp ? 1 : 0; pexp = val; ptag = (n == 4) ? "R5" : "R6";
      end
      if (sp) begin
        m_stall = 1; sec_addr = eff[31:2] + 30'd1; sec_we = we_hi;
        sec_wd = wd_hi; sec_store = st; stag = "R2";
      end else stag = "R4";
    end else stag = "R3";
  endtask

  task automatic acc(input bit st, input logic [1:0] sz, input bit un,
                     input logic [31:0] b, input logic [11:0] im, input logic [31:0] d);
    bit was;
    do begin
      was = m_stall;
      cycle(1, st, sz, un, b, im, d);
    end while (was);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) cycle(0, 0, 2'd0, 0, 32'd0, 12'd0, 32'd0);
  endtask

  task automatic rst_cycle();
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0;
    #2;
    chk(stall == 1'b0, "R8", {31'd0, stall}, 32'd0);
    chk(ld_valid == 1'b0, "R8", {31'd0, ld_valid}, 32'd0);
    chk(ram_en == 1'b0, "R8", {31'd0, ram_en}, 32'd0);
    m_stall = 0; pend = 0; stag = "R8";
  endtask

  initial begin
    for (int a = 0; a < 256; a++) shd[a] = 8'(a * 37 + 11);
    for (int w = 0; w < 64; w++)
      mem[w] = {shd[4*w+3], shd[4*w+2], shd[4*w+1], shd[4*w]};
    for (int i = 0; i < 3; i++) rst_cycle();
    idle(2);
    acc(0, 2'd2, 0, 32'h20, 12'hFF0, 0);
    acc(0, 2'd2, 0, 32'h40, 12'h001, 0);
    acc(0, 2'd2, 0, 32'h40, 12'h002, 0);
    acc(0, 2'd2, 0, 32'h40, 12'h003, 0);
    acc(0, 2'd3, 0, 32'h44, 12'h000, 0);
    for (int o = 0; o < 4; o++) begin
      acc(0, 2'd1, 0, 32'h50 + o, 12'd0, 0);
      acc(0, 2'd1, 1, 32'h50 + o, 12'd0, 0);
      acc(0, 2'd0, 0, 32'h60 + o, 12'd0, 0);
      acc(0, 2'd0, 1, 32'h60 + o, 12'd0, 0);
    end
    idle(2);
    acc(1, 2'd2, 0, 32'h80, 12'h002, 32'h8899AABB);
    acc(1, 2'd1, 0, 32'h8B, 12'h000, 32'h0000C3D4);
    acc(1, 2'd0, 0, 32'h90, 12'h003, 32'h000000F1);
    acc(1, 2'd1, 0, 32'h94, 12'h000, 32'h00007E81);
    acc(0, 2'd2, 0, 32'h80, 12'h002, 0);
    acc(0, 2'd1, 0, 32'h8B, 12'h000, 0);
    acc(0, 2'd2, 0, 32'h88, 12'h000, 0);
    acc(0, 2'd0, 0, 32'h93, 12'h000, 0);
    acc(0, 2'd1, 1, 32'h94, 12'h000, 0);
    acc(0, 2'd2, 0, 32'h400, 12'h7FF, 0);
    acc(0, 2'd2, 0, 32'hFFFFFFFC, 12'h002, 0);
    acc(1, 2'd2, 0, 32'hFFFFFFFF, 12'h000, 32'h13579BDF);
    acc(0, 2'd2, 0, 32'hFFFFFFFF, 12'h000, 0);
    idle(1);
    cycle(1, 0, 2'd2, 0, 32'hA1, 12'd0, 0);
    cycle(1, 1, 2'd2, 0, 32'hB0, 12'd0, 32'hDEADBEEF);
    acc(0, 2'd2, 0, 32'hB0, 12'd0, 0);
    idle(2);
    cycle(1, 0, 2'd2, 0, 32'hC1, 12'd0, 0);
    rst_cycle();
    rst_cycle();
    idle(3);
    acc(0, 2'd0, 1, 32'hC1, 12'd0, 0);
    idle(3);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #4000000;
    nerr++; nchk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule